// File: doc/BRIEF.md
# Parking Bus Arbiter with Background Selection

This block is a central arbiter for a shared bus with several masters. Each master has three wires: a request it raises when it wants the bus, a grant the arbiter returns, and a release pulse it gives when its tenure is over. Exactly one master holds the grant in every cycle. A master may drive the bus only while its grant is high. The grant stays put until the holder releases it. While nobody else is asking, the holder stays parked on the bus and can run as many transactions as it likes without asking again.

The winner of the next tenure is picked in the background and stored in a register while the current tenure runs. When the owner releases, the stored winner takes the grant on that same clock edge, so no idle cycle falls between two tenures. The lowest index has the highest fixed priority. Each master also has an age counter that counts the decisions in which it was left waiting. When a counter reaches the limit, that master is promoted above the fixed order, so even the last master is served within a bounded number of handovers.

Top module: `bus_arb_park`

## Requirements
- R1: In the first cycle after reset, the grant vector equals 1, so the bus is parked on master 0 (grant bit i belongs to master i).
- R2: Exactly one grant bit is high in every cycle.
- R3: The grant changes only at a clock edge where the current owner's release bit is high. Release bits of masters that do not hold the grant have no effect.
- R4: If the owner releases while no other master was seen requesting at the previous edge, the owner keeps the grant (parking).
- R5: If the owner releases while a next winner is pending, the new grant is visible right after that edge, and no cycle passes without a grant.
- R6: The pending winner is taken from the requests sampled at the clock edge before the releasing edge, with the new owner's own request left out. A request that first appears at the releasing edge does not take part in that handover.
- R7: Among the waiting requesters that have not been promoted, the lowest index wins.
- R8: At each handover, every candidate that loses has its age counter raised by one, up to STARVE_LIMIT. The winner's counter and every non-candidate's counter go to 0. A master whose counter equals STARVE_LIMIT is promoted. Promoted masters beat all unpromoted ones, and among promoted masters the lowest index wins.
- R9: An owner whose request drops keeps the grant until it releases. At that release the grant leaves it if another master is waiting, and the handover counts as a normal decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Request per master |
| rel_i | input | N_MASTERS | End-of-tenure pulse per master |
| gnt_o | output | N_MASTERS | Registered one-hot grant |

## Verification
Two events can meet in one clock edge: the owner's release, and a change in the candidate set that feeds the background choice. A request may rise on exactly the releasing edge, and a promotion may fall due on the same handover that changes the owner. The bench provokes the first on purpose by raising a new request together with the release. It provokes the second with saturating contention, in which every master requests and releases in every cycle. Random traffic then mixes both. A bench model follows the documented one-edge lag of the choice and the age update. Each grant is judged against that model and against the stated rule: parked when nothing was pending, handed over when something was.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int DEF_MASTERS      = 4;
  localparam int DEF_STARVE_LIMIT = 4;

  typedef enum logic [1:0] {
    ARB_HOLD     = 2'd0,
    ARB_PARK     = 2'd1,
    ARB_HANDOVER = 2'd2
  } arb_evt_e;
endpackage

// File: rtl/bus_arb_pick.sv
module bus_arb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] cand,
  input  logic [N-1:0] promo,
  output logic [N-1:0] win_oh,
  output logic         any
);
  logic [N-1:0] pool;
  logic [N-1:0] taken;

  always_comb begin
    pool = ((cand & promo) != '0) ? (cand & promo) : cand;
  end

  // lowest index in the pool wins
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pick
      if (g == 0) begin : g_first
        assign win_oh[g] = pool[g];
        assign taken[g]  = pool[g];
      end else begin : g_rest
        assign win_oh[g] = pool[g] & ~taken[g-1];
        assign taken[g]  = pool[g] | taken[g-1];
      end
    end
  endgenerate

  assign any = taken[N-1];
endmodule

// File: rtl/bus_arb_age.sv
module bus_arb_age #(
  parameter int N = 4,
  parameter int K = 4,
  localparam int CW = $clog2(K + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         decide,
  input  logic [N-1:0] cand_q,
  input  logic [N-1:0] win_oh,
  output logic [N-1:0] promo_nxt
);
  localparam logic [CW-1:0] LIMIT = CW'(K);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_age
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (decide) begin
          if (win_oh[g] || !cand_q[g]) cnt_d = '0;
          else if (cnt_q != LIMIT)     cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
      end

      assign promo_nxt[g] = (cnt_d == LIMIT);

      // R8
      cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);
    end
  endgenerate
endmodule

// File: rtl/bus_arb_park.sv
module bus_arb_park
  import bus_arb_pkg::*;
#(
  parameter int N_MASTERS   = DEF_MASTERS,
  parameter int STARVE_LIMIT = DEF_STARVE_LIMIT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] rel_i,
  output logic [N_MASTERS-1:0] gnt_o
);
  localparam logic [N_MASTERS-1:0] PARK0 = {{(N_MASTERS-1){1'b0}}, 1'b1};

  logic [N_MASTERS-1:0] gnt_q, next_oh_q, cand_q;
  logic                 next_vld_q;
  logic [N_MASTERS-1:0] new_oh, cand_d, pick_oh, promo_nxt;
  logic                 pick_any;
  arb_evt_e             evt;

  always_comb begin
    if (!(|(rel_i & gnt_q)))  evt = ARB_HOLD;
    else if (next_vld_q)      evt = ARB_HANDOVER;
    else                      evt = ARB_PARK;
    new_oh = (evt == ARB_HANDOVER) ? next_oh_q : gnt_q;
    cand_d = req_i & ~new_oh;
  end

  bus_arb_age #(.N(N_MASTERS), .K(STARVE_LIMIT)) u_age (
    .clk       (clk),
    .rst       (rst),
    .decide    (evt == ARB_HANDOVER),
    .cand_q    (cand_q),
    .win_oh    (next_oh_q),
    .promo_nxt (promo_nxt)
  );

  bus_arb_pick #(.N(N_MASTERS)) u_pick (
    .cand   (cand_d),
    .promo  (promo_nxt),
    .win_oh (pick_oh),
    .any    (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q      <= PARK0;
      next_oh_q  <= '0;
      next_vld_q <= 1'b0;
      cand_q     <= '0;
    end else begin
      gnt_q      <= new_oh;
      next_oh_q  <= pick_oh;
      next_vld_q <= pick_any;
      cand_q     <= cand_d;
    end
  end

  assign gnt_o = gnt_q;

  // R1
  reset_park_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> gnt_o == PARK0);
  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt_o) == 1);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(rel_i & gnt_o)) |=> $stable(gnt_o));
  // R4
  park_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(rel_i & gnt_o)) && !next_vld_q) |=> $stable(gnt_o));
  // R5
  handover_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(rel_i & gnt_o)) && next_vld_q) |=> !$stable(gnt_o));
endmodule

// File: tb/sim_bus_arb_park.sv
module sim_bus_arb_park;
  localparam int N = 4;
  localparam int K = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] rel_i = '0;
  logic [N-1:0] gnt_o;

  int n_chk = 0;
  int n_fail = 0;
  string phase = "R1";
  bit done = 1'b0;

  // model state
  logic [N-1:0] m_gnt, m_next, m_cand;
  bit           m_vld;
  int           m_cnt [N];

  always #10 clk = ~clk;

  bus_arb_park #(.N_MASTERS(N), .STARVE_LIMIT(K)) u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .rel_i(rel_i), .gnt_o(gnt_o)
  );

  function automatic logic [N-1:0] pick(input logic [N-1:0] c, input int cn [N]);
    logic [N-1:0] pool = '0;
    for (int i = 0; i < N; i++) if (c[i] && cn[i] == K) pool[i] = 1'b1;
    if (pool == '0) pool = c;
    for (int i = 0; i < N; i++) if (pool[i]) return N'(1) << i;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_gnt = N'(1); m_next = '0; m_cand = '0; m_vld = 1'b0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
    end else begin
      if ((rel_i & m_gnt) != '0 && m_vld) begin
        for (int i = 0; i < N; i++) begin
          if (m_next[i] || !m_cand[i]) m_cnt[i] = 0;
          else if (m_cnt[i] < K)       m_cnt[i] = m_cnt[i] + 1;
        end
        m_gnt = m_next;
      end
      m_cand = req_i & ~m_gnt;
      m_next = pick(m_cand, m_cnt);
      m_vld  = (m_cand != '0);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: grant actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check($countones(gnt_o) == 1, "R2", gnt_o, m_gnt);
      check(gnt_o == m_gnt, phase, gnt_o, m_gnt);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
      end
    end
  end

  initial begin
    bit seen3;
    step(3);
    rst = 1'b0;
    step(1);
    check(gnt_o == 4'b0001, "R1", gnt_o, 4'b0001);

    phase = "R3";
    req_i = 4'b0010; step(3);
    rel_i = 4'b0100; step(1); rel_i = '0;
    check(gnt_o == 4'b0001, "R3", gnt_o, 4'b0001);

    phase = "R4";
    req_i = '0; step(3);
    rel_i = 4'b0001; step(1); rel_i = '0;
    check(gnt_o == 4'b0001, "R4", gnt_o, 4'b0001);

    phase = "R5";
    req_i = 4'b0010; step(2);
    rel_i = 4'b0001; step(1); rel_i = '0;
    check(gnt_o == 4'b0010, "R5", gnt_o, 4'b0010);

    phase = "R9";
    req_i = '0; step(4);
    check(gnt_o == 4'b0010, "R9", gnt_o, 4'b0010);
    req_i = 4'b1000; step(2);
    rel_i = 4'b0010; step(1); rel_i = '0;
    check(gnt_o == 4'b1000, "R9", gnt_o, 4'b1000);

    phase = "R7";
    req_i = 4'b0111; step(2);
    rel_i = 4'b1000; step(1); rel_i = '0;
    check(gnt_o == 4'b0001, "R7", gnt_o, 4'b0001);

    phase = "R6";
    req_i = '0; step(3);
    req_i = 4'b0100; rel_i = 4'b0001; step(1); rel_i = '0;
    check(gnt_o == 4'b0001, "R6", gnt_o, 4'b0001);
    step(1);
    rel_i = 4'b0001; step(1); rel_i = '0;
    check(gnt_o == 4'b0100, "R6", gnt_o, 4'b0100);

    phase = "R8";
    seen3 = 1'b0;
    req_i = 4'b1111; rel_i = 4'b1111;
    for (int i = 0; i < 9; i++) begin
      step(1);
      if (gnt_o[3]) seen3 = 1'b1;
    end
    rel_i = '0;
    check(seen3, "R8", gnt_o, 4'b1000);

    phase = "R3 R5 R6 R7 R8 random";
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      req_i = N'($urandom);
      rel_i = (($urandom % 3) == 0) ? N'($urandom) : '0;
      step(1);
    end
    req_i = '0; rel_i = '0;
    step(2);
    finish_run();
  end
endmodule